// File: doc/BRIEF.md
# Sine Tone Synthesizer with Single-Bit PWM Output

This block produces an audio sine tone on one digital pin. A phase accumulator advances once per PWM frame. Its upper byte selects an 8-bit sample from an internal sine table, and that sample sets the duty cycle of the following PWM frame. An external low-pass filter turns the pulse train into the analog tone.

The tone frequency is coarse. An 8-bit control word picks one of seven phase increments, each four times the previous one. A new control word is captured on a valid strobe and is applied at the next frame boundary. An enable input pauses the whole generator and holds the pin low.

Top module: `dds_sine_pwm`

## Requirements
- R1: After reset the phase accumulator and the phase increment are zero, and the duty value is 128. Every frame then has exactly 128 high cycles until a control word is applied.
- R2: A frame is 256 enabled clock cycles, with the counter running 0 to 255. The output is high while the counter is below the duty value. The high cycles therefore form one run at the start of the frame, and that run is as long as the duty value.
- R3: At each frame boundary the accumulator gains the increment modulo 65536. The frame that follows uses the table sample at accumulator bits [15:8] as its duty value.
- R4: The sine table has 256 unsigned 8-bit entries. Entry 0 is 128, entry 64 is 255, entry 128 is 128 and entry 192 is 0. For index i < 128, every entry is within 1 of round(128 + 127·sin(2πi/256)). For index i >= 128, it is within 1 of round(128 + 128·sin(2πi/256)).
- R5: The increment index is control bits [7:5], clamped to 6. The increment is 2·4^index, one of 2, 8, 32, 128, 512, 2048 or 8192.
- R6: A control word is captured only in a cycle where the strobe is high, and it takes effect at the next frame boundary. A control word presented without the strobe has no effect.
- R7: The duty value changes only at a frame boundary. A control word strobed in the middle of a frame leaves that frame's high time unchanged.
- R8: While enable is low, the output is low and the counter and the accumulator hold their values. When enable returns, the frame resumes from the counter value it held, and no boundary is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PWM counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low freezes the generator and forces the output low |
| ctrl_i | input | 8 | Frequency control word; bits [7:5] select the increment |
| ctrl_vld_i | input | 1 | Strobe that captures ctrl_i |
| pwm_o | output | 1 | Single-bit PWM output |

## Verification
The bench measures the high time of every frame and compares it with an arithmetic sine reference. This would expose a table with a wrong quadrant or a wrong peak value, and a duty value taken from the phase before the add instead of after it. Each control word is checked at the region boundaries 0x1F/0x20 and 0xDF/0xE0 and over the clamped top range. Each check runs long enough that neighbouring increments give different samples, so an off-by-one index decode or a missing clamp shows up as a different frame. Pauses are placed inside a frame and on the last count before the boundary. A design that kept counting, skipped a boundary or advanced twice would fall out of step with the model.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // Sine sample for table entry idx of a 2**addr_w table with data_w-bit unsigned output.
    // Uses a rational half-wave approximation. The positive half swings by mid-1 and
    // the negative half by mid, so the peak is the full-scale code and the trough is zero.
    function automatic int sine_sample(int idx, int addr_w, int data_w);
        longint half;
        longint t;
        longint u;
        longint den;
        longint mid;
        longint amp;
        longint mag;
        half = longint'(1) << (addr_w - 1);
        t    = longint'(idx) % half;
        u    = t * (half - t);
        den  = 5 * half * half - 4 * u;
        mid  = longint'(1) << (data_w - 1);
        amp  = (idx < half) ? (mid - 1) : mid;
        mag  = (2 * amp * 16 * u + den) / (2 * den);
        return (idx < half) ? int'(mid + mag) : int'(mid - mag);
    endfunction

    // Phase increment for a clamped selection index: base scaled by 2**(log_ratio*sel).
    function automatic longint step_value(int sel, int nsteps, int base, int log_ratio);
        int s;
        s = (sel < nsteps) ? sel : (nsteps - 1);
        return longint'(base) << (log_ratio * s);
    endfunction

endpackage

// File: rtl/dds_step_sel.sv
module dds_step_sel #(
    parameter int CTRL_W    = 8,
    parameter int SEL_BITS  = 3,
    parameter int PHASE_W   = 16,
    parameter int NSTEPS    = 7,
    parameter int STEP_BASE = 2,
    parameter int STEP_LOG  = 2
) (
    input  logic [CTRL_W-1:0]  ctrl_i,
    output logic [PHASE_W-1:0] step_o
);
    localparam int LUT_N = 2 ** SEL_BITS;

    logic [PHASE_W-1:0] lut [LUT_N];
    logic [SEL_BITS-1:0] sel;

    // Entries past the last valid step repeat it, which implements the clamp.
    for (genvar g = 0; g < LUT_N; g++) begin : g_lut
        assign lut[g] = PHASE_W'(dds_pkg::step_value(g, NSTEPS, STEP_BASE, STEP_LOG));
    end

    assign sel    = ctrl_i[CTRL_W-1 -: SEL_BITS];
    assign step_o = lut[sel];
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = DATA_W'(dds_pkg::sine_sample(g, ADDR_W, DATA_W));
    end

    assign data_o = rom[addr_i];
endmodule

// File: rtl/dds_pwm_core.sv
module dds_pwm_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             wrap_o,
    output logic             pwm_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] DUTY_RST = CNT_W'(1) << (CNT_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] duty;
    } core_t;

    core_t cur_q, cur_d;

    always_comb begin
        cur_d = cur_q;
        if (en_i) begin
            cur_d.cnt = cur_q.cnt + 1'b1;
            if (cur_q.cnt == CNT_MAX) begin
                cur_d.duty = duty_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '{cnt: '0, duty: DUTY_RST};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign wrap_o = en_i && (cur_q.cnt == CNT_MAX);
    assign pwm_o  = en_i && (cur_q.cnt < cur_q.duty);

    AST_DUTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_o |=> $stable(cur_q.duty)); // R7
    AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(cur_q.cnt)); // R8
    AST_CNT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> (cur_q.cnt == CNT_W'($past(cur_q.cnt) + 1'b1))); // R2
endmodule

// File: rtl/dds_sine_pwm.sv
module dds_sine_pwm #(
    parameter int PHASE_W   = 16,
    parameter int SAMP_W    = 8,
    parameter int CTRL_W    = 8,
    parameter int SEL_BITS  = 3,
    parameter int NSTEPS    = 7,
    parameter int STEP_BASE = 2,
    parameter int STEP_LOG  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              ctrl_vld_i,
    output logic              pwm_o
);
    localparam int ADDR_W = SAMP_W;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [PHASE_W-1:0] step;
        logic [PHASE_W-1:0] pend_step;
        logic               pend_vld;
    } gen_t;

    gen_t               st_q, st_d;
    logic [PHASE_W-1:0] sel_step;
    logic [PHASE_W-1:0] step_use;
    logic [SAMP_W-1:0]  duty_next;
    logic               wrap;

    dds_step_sel #(
        .CTRL_W   (CTRL_W),
        .SEL_BITS (SEL_BITS),
        .PHASE_W  (PHASE_W),
        .NSTEPS   (NSTEPS),
        .STEP_BASE(STEP_BASE),
        .STEP_LOG (STEP_LOG)
    ) i_step_sel (
        .ctrl_i(ctrl_i),
        .step_o(sel_step)
    );

    always_comb begin
        st_d     = st_q;
        step_use = st_q.pend_vld ? st_q.pend_step : st_q.step;
        if (wrap) begin
            st_d.step     = step_use;
            st_d.phase    = st_q.phase + step_use;
            st_d.pend_vld = 1'b0;
        end
        // A strobe on the boundary cycle is kept for the following boundary.
        if (ctrl_vld_i) begin
            st_d.pend_step = sel_step;
            st_d.pend_vld  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dds_sine_rom #(
        .ADDR_W(ADDR_W),
        .DATA_W(SAMP_W)
    ) i_rom (
        .addr_i(st_d.phase[PHASE_W-1 -: ADDR_W]),
        .data_o(duty_next)
    );

    dds_pwm_core #(
        .CNT_W(SAMP_W)
    ) i_core (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .duty_i(duty_next),
        .wrap_o(wrap),
        .pwm_o (pwm_o)
    );

    AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> $stable(st_q.phase)); // R3
    AST_PHASE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> (st_q.phase == PHASE_W'($past(st_q.phase) + st_q.step))); // R3
    AST_STEP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(st_q.step)); // R5
    AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> $stable(st_q.step)); // R6
    AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> !pwm_o); // R8
endmodule

// File: tb/test_dds_sine_pwm.sv
module test_dds_sine_pwm;
    localparam int CLK_PERIOD = 10;
    localparam int NCTL = 13;
    localparam logic [7:0] CTL_LIST [NCTL] = '{8'h00, 8'h1F, 8'h20, 8'h3F, 8'h40, 8'h5F,
                                              8'h60, 8'h80, 8'hA0, 8'hC0, 8'hDF, 8'hE0, 8'hFF};
    localparam int CTL_FRAMES [NCTL] = '{130, 40, 34, 34, 10, 10, 4, 3, 3, 3, 3, 3, 3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic [7:0] ctrl = 8'h00;
    logic       vld = 1'b0;
    logic       pwm;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] ph_m;
    logic [15:0] st_m;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dds_sine_pwm i_dds_sine_pwm (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .en_i      (en),
        .ctrl_i    (ctrl),
        .ctrl_vld_i(vld),
        .pwm_o     (pwm)
    );

    function automatic int ref_duty(int idx);
        real a;
        real r;
        a = 2.0 * 3.14159265358979 * idx / 256.0;
        if (idx < 128) r = 128.0 + 127.0 * $sin(a);
        else           r = 128.0 + 128.0 * $sin(a);
        return $rtoi(r + 0.5);
    endfunction

    function automatic logic [15:0] step_of(logic [7:0] c);
        int k;
        k = int'(c >> 5);
        if (k > 6) k = 6;
        return 16'(2 << (2 * k));
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en    = 1'b1;
        vld   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ph_m  = '0;
        st_m  = '0;
    endtask

    // Entered at a negedge with counter 0; leaves at the negedge of the next frame start.
    task automatic run_frame(bit do_ctl, logic [7:0] c, int dis_at, int dis_len, string tag);
        int highs = 0;
        bit fell = 0;
        bit gap = 0;
        int off_bad = 0;
        int idx = int'(ph_m[15:8]);
        int exp = ref_duty(idx);
        for (int i = 0; i < 256; i++) begin
            if (pwm) begin
                highs++;
                if (fell) gap = 1;
            end else begin
                fell = 1;
            end
            if (do_ctl && i == 10) begin
                ctrl = c;
                vld  = 1'b1;
            end
            if (do_ctl && i == 11) vld = 1'b0;
            if (i == dis_at) begin
                en = 1'b0;
                for (int k = 0; k < dis_len; k++) begin
                    #1;
                    if (pwm) off_bad++;
                    @(negedge clk);
                end
                en = 1'b1;
            end
            @(negedge clk);
        end
        check(gap == 0, {tag, " R2 single high run"}, gap, 0);
        check((highs - exp <= 1) && (exp - highs <= 1), {tag, " duty vs sine"}, highs, exp);
        if (idx == 0 || idx == 128) check(highs == 128, {tag, " R4 mid"}, highs, 128);
        if (idx == 64)  check(highs == 255, {tag, " R4 peak"}, highs, 255);
        if (idx == 192) check(highs == 0, {tag, " R4 trough"}, highs, 0);
        if (dis_at >= 0) check(off_bad == 0, {tag, " R8 low while off"}, off_bad, 0);
        if (do_ctl) st_m = step_of(c);
        ph_m = ph_m + st_m;
    endtask

    initial begin
        do_reset();
        // R1: reset duty 128, no motion
        check(pwm == 1'b1, "R1 output high at frame start", pwm, 1);
        run_frame(0, 8'h00, -1, 0, "R1");
        run_frame(0, 8'h00, -1, 0, "R1");
        // R6: control word without strobe is ignored
        ctrl = 8'hFF;
        run_frame(0, 8'h00, -1, 0, "R6");
        run_frame(0, 8'h00, -1, 0, "R6");
        // R6/R7: strobe mid-frame, applied only at the boundary
        run_frame(1, 8'hFF, -1, 0, "R7");
        // R3: accumulator wraps after eight frames of step 8192
        for (int f = 0; f < 10; f++) run_frame(0, 8'h00, -1, 0, "R3");
        // R8: pauses mid-frame and on the last count
        run_frame(0, 8'h00, 100, 37, "R8");
        run_frame(0, 8'h00, 255, 20, "R8");
        run_frame(0, 8'h00, 0, 5, "R8");
        for (int f = 0; f < 3; f++) run_frame(0, 8'h00, -1, 0, "R8");
        // R5: increment decode at region edges and the clamp
        for (int j = 0; j < NCTL; j++) begin
            do_reset();
            run_frame(1, CTL_LIST[j], -1, 0, "R5");
            for (int f = 0; f < CTL_FRAMES[j]; f++) run_frame(0, 8'h00, -1, 0, "R5");
        end
        // R4: table sweep over all even indices with step 512
        do_reset();
        run_frame(1, 8'h80, -1, 0, "R4");
        for (int f = 0; f < 129; f++) run_frame(0, 8'h00, -1, 0, "R4");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule